// File: doc/BRIEF.md
# Running-Variance Colour Classifier

This block takes a pixel stream in which each pixel is tagged as coming from the red or the blue colour plane. It gathers per-image statistics while the image streams past and makes a two-feature decision once the image has ended. Red pixels brighter than a fixed background level are taken to belong to the object. For these pixels the block keeps a count, a sum of intensities and a sum of squared intensities. Blue pixels count as dark when they are above the background level and below an upper bound that is chosen by a 4-bit code.

When the image ends, a short arithmetic pipeline tests whether the red variance is above 2500. It does this without a divider, by comparing N·Σx² − (Σx)² with 2500·N². The object is flagged as the dark, varied class only when the variance test passes and the dark-blue count is also above 50. The result is registered, a one-cycle done strobe marks it, and the raw statistics stay readable until the next image starts.

Top module: `colour_spread_classifier`

## Requirements
- R1: After reset, every output is zero: the class flag, the done strobe, the red count, the red sum, the red sum of squares and the dark-blue count.
- R2: A valid pixel with pixIsBlue = 0 is red. A red pixel with intensity greater than 15 adds 1 to redCount, adds its intensity to redSum and adds its square to redSumSq. A red pixel with intensity 15 or less changes none of these.
- R3: A valid pixel with pixIsBlue = 1 adds 1 to blueDarkCount when its intensity is greater than 15 and less than 60 + 4·bandCode. For example, the bound is 60 for code 0 and 120 for code 15.
- R4: A frameStart pulse, taken while no result is being computed, clears all four statistics. A valid pixel in the same cycle as frameStart counts as the first pixel of the new image.
- R5: Valid pixels that arrive after the frameEnd cycle and before the next frameStart leave all four statistics unchanged.
- R6: The class flag is 1 exactly when N·Σx² − (Σx)² > 2500·N² and blueDarkCount > 50, where N, Σx and Σx² are the red statistics. A variance of exactly 2500, or exactly 50 dark pixels, gives 0.
- R7: If fewer than two red pixels were included, the class flag is 0 whatever the other statistics are.
- R8: resultDone is high for exactly one cycle, three clock edges after the edge that samples frameEnd. The class flag takes its new value in that same cycle and holds it until the next done strobe.
- R9: The statistics are exact, with no wrap, for images of up to 40,000 included pixels at full intensity 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start-of-image pulse |
| frameEnd | input | 1 | End-of-image pulse |
| pixValid | input | 1 | Pixel qualifier |
| pixIsBlue | input | 1 | Plane tag: 0 red, 1 blue |
| pixData | input | 8 | Pixel intensity |
| bandCode | input | 4 | Selects the upper bound of the dark-blue band |
| isVariedDark | output | 1 | Class flag |
| resultDone | output | 1 | One-cycle strobe when a result is ready |
| redCount | output | 16 | Number of included red pixels |
| redSum | output | 24 | Sum of included red intensities |
| redSumSq | output | 32 | Sum of squared included red intensities |
| blueDarkCount | output | 16 | Number of blue pixels inside the dark band |

## Verification
Every red intensity from 0 to 255 is sent as a single-pixel image. This separates the background cut at 15 from the object range, checks the sum and square arithmetic for each value, and confirms that a single pixel never sets the flag. For every band code, all 256 blue intensities are sent, which exposes off-by-one errors at both edges of the band. Two-level red images whose variance is exactly 2500 or 2601, combined with 50 or 51 dark pixels, probe both comparisons at their thresholds. Two-pixel and one-pixel images bracket the minimum red count. A full-size image at intensity 255, pixels sent outside an image, and a pixel that arrives with frameStart cover wrap-around, the idle state and clearing.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCUM,
    ST_CALC1,
    ST_CALC2,
    ST_CALC3
  } cscState_t;

  typedef struct packed {
    logic clearAcc;
    logic accEn;
    logic calc1;
    logic calc2;
    logic calc3;
  } cscStrobes_t;
endpackage

// File: rtl/csc_control.sv
module csc_control
  import csc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        frameEnd,
  output cscStrobes_t strb
);
  cscState_t state, stateNext;
  logic      openState;

  assign openState = (state == ST_IDLE) || (state == ST_ACCUM);

  always_comb begin
    strb          = '0;
    strb.clearAcc = openState && frameStart;
    strb.accEn    = (state == ST_ACCUM) || strb.clearAcc;
    strb.calc1    = (state == ST_CALC1);
    strb.calc2    = (state == ST_CALC2);
    strb.calc3    = (state == ST_CALC3);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (frameStart) stateNext = frameEnd ? ST_CALC1 : ST_ACCUM;
      ST_ACCUM: if (frameEnd) stateNext = ST_CALC1;
      ST_CALC1: stateNext = ST_CALC2;
      ST_CALC2: stateNext = ST_CALC3;
      ST_CALC3: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_CALC_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.calc1 |=> strb.calc2) else $error("calc sequence broken"); // R8
  AST_CALC_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.calc3 |=> (state == ST_IDLE)) else $error("calc3 not followed by idle"); // R8
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int CODE_W    = 4,
  parameter int MAX_PIX   = 40000,
  parameter int BG_LEVEL  = 15,
  parameter int BAND_BASE = 60,
  parameter int BAND_STEP = 4,
  parameter int VAR_LIMIT = 2500,
  parameter int DARK_MIN  = 50,
  localparam int CNT_W    = $clog2(MAX_PIX + 1),
  localparam int SUM_W    = PIX_W + CNT_W,
  localparam int SQ_W     = 2 * PIX_W + CNT_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  cscStrobes_t       strb,
  input  logic              pixValid,
  input  logic              pixIsBlue,
  input  logic [PIX_W-1:0]  pixData,
  input  logic [CODE_W-1:0] bandCode,
  output logic              isVariedDark,
  output logic              resultDone,
  output logic [CNT_W-1:0]  redCount,
  output logic [SUM_W-1:0]  redSum,
  output logic [SQ_W-1:0]   redSumSq,
  output logic [CNT_W-1:0]  blueDarkCount
);
  localparam int LIM_W  = PIX_W + 2;
  localparam int PROD_W = CNT_W + SQ_W;

  logic [LIM_W-1:0]   bandLimit;
  logic               redHit, blueHit;
  logic [2*PIX_W-1:0] pixSq;
  logic [PROD_W-1:0]  nTimesSq, sumSquared, spread, thrTerm;
  logic [2*CNT_W-1:0] nSquared;

  assign bandLimit = LIM_W'(BAND_BASE) + LIM_W'(BAND_STEP) * LIM_W'(bandCode);
  assign redHit    = pixValid && !pixIsBlue && (pixData > PIX_W'(BG_LEVEL));
  assign blueHit   = pixValid && pixIsBlue && (pixData > PIX_W'(BG_LEVEL))
                     && (LIM_W'(pixData) < bandLimit);
  assign pixSq     = (2*PIX_W)'(pixData) * (2*PIX_W)'(pixData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redCount      <= '0;
      redSum        <= '0;
      redSumSq      <= '0;
      blueDarkCount <= '0;
    end else if (strb.accEn) begin
      redCount      <= (strb.clearAcc ? '0 : redCount) + CNT_W'(redHit);
      redSum        <= (strb.clearAcc ? '0 : redSum) + (redHit ? SUM_W'(pixData) : '0);
      redSumSq      <= (strb.clearAcc ? '0 : redSumSq) + (redHit ? SQ_W'(pixSq) : '0);
      blueDarkCount <= (strb.clearAcc ? '0 : blueDarkCount) + CNT_W'(blueHit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nTimesSq     <= '0;
      sumSquared   <= '0;
      nSquared     <= '0;
      spread       <= '0;
      thrTerm      <= '0;
      isVariedDark <= 1'b0;
      resultDone   <= 1'b0;
    end else begin
      resultDone <= strb.calc3;
      if (strb.calc1) begin
        nTimesSq   <= PROD_W'(redCount) * PROD_W'(redSumSq);
        sumSquared <= PROD_W'(redSum) * PROD_W'(redSum);
        nSquared   <= (2*CNT_W)'(redCount) * (2*CNT_W)'(redCount);
      end
      if (strb.calc2) begin
        spread  <= nTimesSq - sumSquared;
        thrTerm <= PROD_W'(nSquared) * PROD_W'(VAR_LIMIT);
      end
      if (strb.calc3)
        isVariedDark <= (redCount >= CNT_W'(2)) && (spread > thrTerm)
                        && (blueDarkCount > CNT_W'(DARK_MIN));
    end
  end

  AST_SPREAD_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    strb.calc2 |-> (nTimesSq >= sumSquared)) else $error("negative spread"); // R9
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    PROD_W'(redSum) <= PROD_W'(redCount) * PROD_W'((1 << PIX_W) - 1)) else $error("sum bound"); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultDone |=> !resultDone) else $error("done wider than a cycle"); // R8
  AST_FLAG_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (resultDone && isVariedDark) |-> (redCount >= CNT_W'(2))
      && (blueDarkCount > CNT_W'(DARK_MIN))) else $error("flag without support"); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.calc3 |=> $stable(isVariedDark)) else $error("flag moved between results"); // R8
endmodule

// File: rtl/colour_spread_classifier.sv
module colour_spread_classifier
  import csc_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int CODE_W    = 4,
  parameter int MAX_PIX   = 40000,
  parameter int BG_LEVEL  = 15,
  parameter int BAND_BASE = 60,
  parameter int BAND_STEP = 4,
  parameter int VAR_LIMIT = 2500,
  parameter int DARK_MIN  = 50,
  localparam int CNT_W    = $clog2(MAX_PIX + 1),
  localparam int SUM_W    = PIX_W + CNT_W,
  localparam int SQ_W     = 2 * PIX_W + CNT_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              pixValid,
  input  logic              pixIsBlue,
  input  logic [PIX_W-1:0]  pixData,
  input  logic [CODE_W-1:0] bandCode,
  output logic              isVariedDark,
  output logic              resultDone,
  output logic [CNT_W-1:0]  redCount,
  output logic [SUM_W-1:0]  redSum,
  output logic [SQ_W-1:0]   redSumSq,
  output logic [CNT_W-1:0]  blueDarkCount
);
  cscStrobes_t strb;

  csc_control ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd), .strb(strb)
  );

  csc_datapath #(
    .PIX_W(PIX_W), .CODE_W(CODE_W), .MAX_PIX(MAX_PIX), .BG_LEVEL(BG_LEVEL),
    .BAND_BASE(BAND_BASE), .BAND_STEP(BAND_STEP), .VAR_LIMIT(VAR_LIMIT),
    .DARK_MIN(DARK_MIN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .pixValid(pixValid), .pixIsBlue(pixIsBlue),
    .pixData(pixData), .bandCode(bandCode), .isVariedDark(isVariedDark),
    .resultDone(resultDone), .redCount(redCount), .redSum(redSum),
    .redSumSq(redSumSq), .blueDarkCount(blueDarkCount)
  );

  AST_IDLE_IGNORES_PIXELS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accEn) |=> ($stable(redCount) && $stable(redSum) && $stable(redSumSq)
                       && $stable(blueDarkCount))) else $error("stats moved outside image"); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearAcc && !pixValid) |=> (redCount == '0) && (blueDarkCount == '0)) else $error("start did not clear"); // R4
endmodule

// File: tb/colour_spread_classifier_tb_top.sv
`timescale 1ns/1ps
module colour_spread_classifier_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0, frameEnd = 1'b0, pixValid = 1'b0, pixIsBlue = 1'b0;
  logic [7:0]  pixData = '0;
  logic [3:0]  bandCode = '0;
  logic        isVariedDark, resultDone;
  logic [15:0] redCount, blueDarkCount;
  logic [23:0] redSum;
  logic [31:0] redSumSq;

  int    checks = 0, fails = 0;
  bit    finished = 1'b0;
  longint mN, mS, mQ, mB;

  always #2.5 clk = ~clk;

  colour_spread_classifier dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .pixValid(pixValid), .pixIsBlue(pixIsBlue), .pixData(pixData), .bandCode(bandCode),
    .isVariedDark(isVariedDark), .resultDone(resultDone), .redCount(redCount),
    .redSum(redSum), .redSumSq(redSumSq), .blueDarkCount(blueDarkCount)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelPix(input bit blue, input int v);
    if (!blue && v > 15) begin mN++; mS += v; mQ += v * v; end
    if (blue && v > 15 && v < 60 + 4 * bandCode) mB++;
  endtask

  task automatic beginFrame(input bit withPix, input bit blue, input int v);
    @(negedge clk);
    frameStart = 1'b1; pixValid = withPix; pixIsBlue = blue; pixData = 8'(v);
    mN = 0; mS = 0; mQ = 0; mB = 0;
    if (withPix) modelPix(blue, v);
    @(negedge clk);
    frameStart = 1'b0; pixValid = 1'b0;
  endtask

  task automatic sendPix(input bit blue, input int v, input int reps);
    for (int i = 0; i < reps; i++) begin
      pixValid = 1'b1; pixIsBlue = blue; pixData = 8'(v);
      modelPix(blue, v);
      @(negedge clk);
    end
    pixValid = 1'b0;
  endtask

  function automatic bit expFlag();
    return (mN >= 2) && (mN * mQ - mS * mS > 2500 * mN * mN) && (mB > 50);
  endfunction

  task automatic endFrame(input string req);
    int early;
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    early = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (resultDone) early++;
    end
    @(negedge clk);
    chk("R8 done timing", {early, resultDone}, 1);
    chk({req, " flag"}, isVariedDark, expFlag());
    chk("R2 R9 stats", (redCount == mN) && (redSum == mS) && (redSumSq == mQ), 1);
    chk("R3 blue count", blueDarkCount, mB);
    @(negedge clk);
    chk("R8 done one cycle", resultDone, 0);
  endtask

  task automatic varFrame(input int lo, input int hi, input int half, input int blues, input string req);
    bandCode = 4'd15;
    beginFrame(1'b0, 1'b0, 0);
    sendPix(1'b0, lo, half);
    sendPix(1'b0, 5, 7);
    sendPix(1'b0, hi, half);
    sendPix(1'b1, 30, blues);
    endFrame(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit f0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {isVariedDark, resultDone, redCount, redSum, redSumSq, blueDarkCount}, 0);
    rstN = 1'b1;

    // R2 R7: each red level as a one-pixel image
    for (int v = 0; v < 256; v++) begin
      beginFrame(1'b0, 1'b0, 0);
      sendPix(1'b1, 30, 60);
      sendPix(1'b0, v, 1);
      endFrame("R7 single red");
    end

    // R3: every blue level for every band code
    for (int c = 0; c < 16; c++) begin
      bandCode = 4'(c);
      beginFrame(1'b0, 1'b0, 0);
      for (int v = 0; v < 256; v++) sendPix(1'b1, v, 1);
      endFrame("R3 band");
      chk("R3 band width", blueDarkCount, 60 + 4 * c - 16);
    end

    // R6: variance and dark-count thresholds
    varFrame(20, 120, 30, 51, "R6 var 2500");
    chk("R6 var equal limit", isVariedDark, 0);
    varFrame(20, 122, 30, 51, "R6 var 2601");
    chk("R6 var above limit", isVariedDark, 1);
    varFrame(20, 122, 30, 50, "R6 dark 50");
    chk("R6 dark at limit", isVariedDark, 0);
    varFrame(16, 255, 1, 51, "R7 two pixels");
    chk("R7 two red pixels", isVariedDark, 1);
    varFrame(16, 255, 0, 80, "R7 no red");
    chk("R7 zero red", isVariedDark, 0);

    // R4: pixel with frameStart, and clearing of previous stats
    beginFrame(1'b1, 1'b0, 200);
    endFrame("R4 start pixel");
    chk("R4 first pixel kept", redSum, 200);

    // R5: pixels outside an image leave the stats and flag alone
    f0 = isVariedDark;
    sendPix(1'b0, 100, 5);
    sendPix(1'b1, 30, 5);
    @(negedge clk);
    chk("R5 idle red", redCount, 1);
    chk("R5 idle blue", blueDarkCount, 0);
    chk("R5 idle flag", isVariedDark, f0);

    // R9: full-size image at maximum intensity
    beginFrame(1'b0, 1'b0, 0);
    sendPix(1'b0, 255, 40000);
    endFrame("R9 full image");
    chk("R9 sum of squares", redSumSq, 64'd40000 * 65025);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule